// File: doc/BRIEF.md
# Flash Controller Command Sequencer

This block is the command front end of an on-chip flash memory. It is modelled here around a small register array that stands in for the flash cells. Software reaches it over a simple 32-bit register bus with five registers: key, control, address, status and wait-state. A separate array write port carries program data, and a read port returns array words.

The controller comes out of reset locked. It accepts page erase, mass erase, single-word program and paired double-word program commands only after the correct two-value key sequence. Each accepted operation holds a busy flag for a number of cycles that scales with the wait-state setting. When the operation completes, the block commits the result to the array and raises an end-of-operation flag.

Failed commands never touch the array. They raise a write-protection, program or alignment error flag instead. All flags clear by writing one to them. An encoded state field reports the most important condition, and an interrupt output combines the flags with two enable bits.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the controller is locked: control register (offset 1) reads 0x80, status (offset 3) reads 0, and `irq` is low. Writing KEY_A and then KEY_B to the key register (offset 0) clears control bit 7 (lock).
- R2: Writing control with bit 7 set re-locks the controller at any time. A key write that does not match the value expected next leaves the controller locked until reset, even if the correct pair follows.
- R3: While locked, writes to the control mode bits (0 program, 1 page erase, 2 mass erase, 3 start, 4 wide, 5 end irq enable, 6 error irq enable), to the address register (offset 2), to the wait-state register (offset 4) and to the array have no effect.
- R4: A control write with bits 1 and 3 set erases, to all ones, the page (PAGE_WORDS words) holding the address register. A control write with bits 2 and 3 set erases every page that is not write-protected.
- R5: With control bit 0 set and bit 4 clear, an array write to byte address A programs word A>>2; address bits [1:0] are ignored.
- R6: With control bits 0 and 4 set, a write to an 8-byte-aligned address A followed by a write to A+4 programs both words as one operation. Nothing is written after the first write alone.
- R7: A program or page erase that targets one of the lowest WP_PAGES pages sets status bit 3 (write-protection error) and leaves the array unchanged.
- R8: Programming a word that is not all ones sets status bit 1 (program error) and leaves the array unchanged.
- R9: In double-word mode, a first address that is not 8-byte aligned, or a second address other than first+4, sets status bit 2 (alignment error) and programs nothing.
- R10: An accepted operation holds status bit 0 (busy) for BUSY_CYC*(wait-state+1) cycles. It then updates the array and sets status bit 4 (end of operation).
- R11: Writing 1 to status bits 1 to 4 clears exactly those flags; other flags stay.
- R12: Status bits [10:8] report, in priority order: 1 busy, 2 write-protection error, 3 program error, 4 alignment error, 0 ready.
- R13: `irq` is high when status bit 4 is set with control bit 5 on, or when an error flag is set with control bit 6 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | register word offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| arr_wr | input | 1 | array program write strobe |
| arr_addr | input | log2(WORDS)+2 | array byte address |
| arr_wdata | input | 32 | program data |
| arr_raddr | input | log2(WORDS) | array read word index |
| arr_rdata | output | 32 | array read data |
| irq | output | 1 | combined interrupt |

## Verification
Single-word programming is driven from a vector table with four kinds of entry: erased targets, already-programmed targets, protected-page targets, and addresses with nonzero low bits. Each entry's resulting flags and readback word show which of success, program error and protection error was chosen.

Double-word programming is tried three ways: an aligned pair, a misaligned first address, and a mismatched second address. These cases separate a real paired commit from the alignment path.

Erase is tried with a nonzero wait state to pin down the busy length. A cluster of simultaneous error flags is cleared one at a time, which exposes the state-code priority.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
   // register word offsets
   localparam logic [2:0] OFS_KEY  = 3'd0;
   localparam logic [2:0] OFS_CTRL = 3'd1;
   localparam logic [2:0] OFS_ADDR = 3'd2;
   localparam logic [2:0] OFS_STAT = 3'd3;
   localparam logic [2:0] OFS_WAIT = 3'd4;

   // control bit positions
   localparam int C_PROG   = 0;
   localparam int C_PERASE = 1;
   localparam int C_MERASE = 2;
   localparam int C_START  = 3;
   localparam int C_WIDE   = 4;
   localparam int C_EIE    = 5;
   localparam int C_RIE    = 6;
   localparam int C_LOCK   = 7;

   // status bit positions
   localparam int S_PERR = 1;
   localparam int S_AERR = 2;
   localparam int S_WERR = 3;
   localparam int S_DONE = 4;

   typedef enum logic [2:0] {
      ST_READY = 3'd0,
      ST_BUSY  = 3'd1,
      ST_WPERR = 3'd2,
      ST_PGERR = 3'd3,
      ST_ALERR = 3'd4
   } fsq_state_e;

   typedef enum logic [1:0] {
      OP_PAGE  = 2'd0,
      OP_MASS  = 2'd1,
      OP_WORD  = 2'd2,
      OP_DWORD = 2'd3
   } fsq_op_e;
endpackage

// File: rtl/fsq_keylock.sv
module fsq_keylock #(
   parameter logic [31:0] KEY_A = 32'h1357_9BDF,
   parameter logic [31:0] KEY_B = 32'h2468_ACE0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [31:0] key_val,
   input  logic        relock,
   output logic        locked
);
   logic stage_q;
   logic dead_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked  <= 1'b1;
         stage_q <= 1'b0;
         dead_q  <= 1'b0;
      end else if (relock) begin
         locked  <= 1'b1;
         stage_q <= 1'b0;
      end else if (key_wr && locked && !dead_q) begin
         if (!stage_q) begin
            if (key_val == KEY_A) stage_q <= 1'b1;
            else                  dead_q  <= 1'b1;
         end else begin
            stage_q <= 1'b0;
            if (key_val == KEY_B) locked <= 1'b0;
            else                  dead_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fsq_timer.sv
module fsq_timer #(
   parameter int BUSY_CYC = 16,
   parameter int WS_W     = 2,
   parameter bit SCALE_WS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  logic [WS_W-1:0] ws,
   output logic            busy,
   output logic            op_end
);
   localparam int MAXC  = BUSY_CYC * (2 ** WS_W);
   localparam int CNT_W = $clog2(MAXC + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_v;

   if (BUSY_CYC < 1) begin : g_bad_cyc
      $error("BUSY_CYC must be at least 1");
   end

   if (SCALE_WS) begin : g_scaled
      assign load_v = CNT_W'(BUSY_CYC) * (CNT_W'(ws) + CNT_W'(1));
   end else begin : g_flat
      logic unused_ws;
      assign unused_ws = ^ws;
      assign load_v    = CNT_W'(BUSY_CYC);
   end

   assign busy   = (cnt_q != '0);
   assign op_end = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (launch) cnt_q <= load_v;
      else if (busy)   cnt_q <= cnt_q - CNT_W'(1);
   end
endmodule

// File: rtl/fsq_array.sv
module fsq_array
   import fsq_pkg::*;
#(
   parameter int WORDS      = 64,
   parameter int PAGE_WORDS = 8,
   parameter int WP_PAGES   = 1,
   localparam int IDX_W     = $clog2(WORDS),
   localparam int PW_W      = $clog2(PAGE_WORDS),
   localparam int PAGES     = WORDS / PAGE_WORDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  fsq_op_e          op,
   input  logic [IDX_W-1:0] op_idx,
   input  logic [31:0]      d0,
   input  logic [31:0]      d1,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_data,
   input  logic [IDX_W-1:0] chk_idx,
   output logic [31:0]      chk0,
   output logic [31:0]      chk1,
   output logic [PAGES-1:0] page_prot
);
   logic [31:0]       mem [WORDS];
   logic [IDX_W-PW_W-1:0] op_pg;

   for (genvar p = 0; p < PAGES; p++) begin : g_prot
      assign page_prot[p] = (p < WP_PAGES);
   end

   assign op_pg   = op_idx[IDX_W-1:PW_W];
   assign rd_data = mem[rd_idx];
   assign chk0    = mem[chk_idx];
   assign chk1    = mem[chk_idx + IDX_W'(1)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '1;
      end else if (commit) begin
         case (op)
            OP_PAGE: begin
               for (int w = 0; w < WORDS; w++)
                  if ((w / PAGE_WORDS) == int'(op_pg)) mem[w] <= '1;
            end
            OP_MASS: begin
               for (int w = 0; w < WORDS; w++)
                  if (!page_prot[w / PAGE_WORDS]) mem[w] <= '1;
            end
            OP_WORD: mem[op_idx] <= d0;
            default: begin
               mem[op_idx]               <= d0;
               mem[op_idx + IDX_W'(1)]   <= d1;
            end
         endcase
      end
   end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fsq_pkg::*;
#(
   parameter int          WORDS      = 64,
   parameter int          PAGE_WORDS = 8,
   parameter int          WP_PAGES   = 1,
   parameter int          BUSY_CYC   = 16,
   parameter int          WS_W       = 2,
   parameter bit          SCALE_WS   = 1'b1,
   parameter logic [31:0] KEY_A      = 32'h1357_9BDF,
   parameter logic [31:0] KEY_B      = 32'h2468_ACE0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [2:0]                 reg_addr,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   input  logic                       arr_wr,
   input  logic [$clog2(WORDS)+1:0]   arr_addr,
   input  logic [31:0]                arr_wdata,
   input  logic [$clog2(WORDS)-1:0]   arr_raddr,
   output logic [31:0]                arr_rdata,
   output logic                       irq
);
   localparam int IDX_W = $clog2(WORDS);
   localparam int AW    = IDX_W + 2;
   localparam int PW_W  = $clog2(PAGE_WORDS);
   localparam int PAGES = WORDS / PAGE_WORDS;

   if ((WORDS % PAGE_WORDS) != 0 || PAGES < 2) begin : g_bad_geom
      $error("WORDS must hold at least two whole pages");
   end
   if ((1 << PW_W) != PAGE_WORDS || (1 << IDX_W) != WORDS) begin : g_bad_pow
      $error("WORDS and PAGE_WORDS must be powers of two");
   end
   if (WP_PAGES > PAGES) begin : g_bad_wp
      $error("WP_PAGES exceeds page count");
   end

   logic wr_key, wr_ctrl, wr_addr, wr_stat, wr_wait, relock;
   logic locked, busy, op_end;
   logic m_prog, m_perase, m_merase, m_wide, eie, rie;
   logic [AW-1:0]    addr_q;
   logic [WS_W-1:0]  ws_q;
   logic perr, aerr, werr, done;
   logic pend;
   logic [IDX_W-1:0] pend_idx;
   logic [31:0]      pend_d0;
   fsq_op_e          op_q, op_n;
   logic [IDX_W-1:0] op_idx_q, idx_n, chk_idx;
   logic [31:0]      d0_q, d1_q, d0_n, d1_n, chk0, chk1;
   logic [PAGES-1:0] page_prot;
   logic launch, set_p, set_a, set_w, pend_set, pend_clr;
   logic prot_arr, prot_pend, prot_adr;
   fsq_state_e st_code;

   assign wr_key  = reg_wr && (reg_addr == OFS_KEY);
   assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
   assign wr_addr = reg_wr && (reg_addr == OFS_ADDR);
   assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
   assign wr_wait = reg_wr && (reg_addr == OFS_WAIT);
   assign relock  = wr_ctrl && reg_wdata[C_LOCK];

   fsq_keylock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
      .clk(clk), .rst_n(rst_n), .key_wr(wr_key), .key_val(reg_wdata),
      .relock(relock), .locked(locked)
   );

   fsq_timer #(.BUSY_CYC(BUSY_CYC), .WS_W(WS_W), .SCALE_WS(SCALE_WS)) u_timer (
      .clk(clk), .rst_n(rst_n), .launch(launch), .ws(ws_q),
      .busy(busy), .op_end(op_end)
   );

   assign chk_idx = (m_wide && pend) ? pend_idx : arr_addr[AW-1:2];

   fsq_array #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS), .WP_PAGES(WP_PAGES)) u_array (
      .clk(clk), .rst_n(rst_n), .commit(op_end), .op(op_q), .op_idx(op_idx_q),
      .d0(d0_q), .d1(d1_q), .rd_idx(arr_raddr), .rd_data(arr_rdata),
      .chk_idx(chk_idx), .chk0(chk0), .chk1(chk1), .page_prot(page_prot)
   );

   assign prot_arr  = page_prot[arr_addr[AW-1:PW_W+2]];
   assign prot_pend = page_prot[pend_idx[IDX_W-1:PW_W]];
   assign prot_adr  = page_prot[addr_q[AW-1:PW_W+2]];

   // command acceptance and error classification
   always_comb begin
      launch   = 1'b0;
      op_n     = OP_WORD;
      idx_n    = arr_addr[AW-1:2];
      d0_n     = arr_wdata;
      d1_n     = arr_wdata;
      set_p    = 1'b0;
      set_a    = 1'b0;
      set_w    = 1'b0;
      pend_set = 1'b0;
      pend_clr = 1'b0;
      if (!locked && !busy) begin
         if (wr_ctrl && reg_wdata[C_START] && !reg_wdata[C_LOCK]) begin
            if (reg_wdata[C_PERASE]) begin
               idx_n = addr_q[AW-1:2];
               if (prot_adr) set_w = 1'b1;
               else begin launch = 1'b1; op_n = OP_PAGE; end
            end else if (reg_wdata[C_MERASE]) begin
               launch = 1'b1;
               op_n   = OP_MASS;
            end
         end else if (arr_wr && m_prog) begin
            if (!m_wide) begin
               if (prot_arr)          set_w  = 1'b1;
               else if (chk0 != '1)   set_p  = 1'b1;
               else                   launch = 1'b1;
            end else if (!pend) begin
               if (arr_addr[2:0] != 3'd0) set_a    = 1'b1;
               else                       pend_set = 1'b1;
            end else begin
               pend_clr = 1'b1;
               idx_n    = pend_idx;
               d0_n     = pend_d0;
               if (arr_addr[AW-1:2] != pend_idx + IDX_W'(1)) set_a = 1'b1;
               else if (prot_pend)                            set_w = 1'b1;
               else if (chk0 != '1 || chk1 != '1)             set_p = 1'b1;
               else begin launch = 1'b1; op_n = OP_DWORD; end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_prog, m_perase, m_merase, m_wide, eie, rie} <= '0;
         addr_q   <= '0;
         ws_q     <= '0;
         {perr, aerr, werr, done} <= '0;
         pend     <= 1'b0;
         pend_idx <= '0;
         pend_d0  <= '0;
         op_q     <= OP_WORD;
         op_idx_q <= '0;
         d0_q     <= '0;
         d1_q     <= '0;
      end else begin
         if (wr_ctrl && !locked) begin
            eie <= reg_wdata[C_EIE];
            rie <= reg_wdata[C_RIE];
            if (!busy) begin
               m_prog   <= reg_wdata[C_PROG];
               m_perase <= reg_wdata[C_PERASE];
               m_merase <= reg_wdata[C_MERASE];
               m_wide   <= reg_wdata[C_WIDE];
            end
         end
         if (wr_addr && !locked && !busy) addr_q <= reg_wdata[AW-1:0];
         if (wr_wait && !locked && !busy) ws_q   <= reg_wdata[WS_W-1:0];

         if (pend_set) begin
            pend     <= 1'b1;
            pend_idx <= arr_addr[AW-1:2];
            pend_d0  <= arr_wdata;
         end else if (pend_clr || relock ||
                      (wr_ctrl && !(reg_wdata[C_PROG] && reg_wdata[C_WIDE]))) begin
            pend <= 1'b0;
         end

         if (wr_stat) begin
            if (reg_wdata[S_PERR]) perr <= 1'b0;
            if (reg_wdata[S_AERR]) aerr <= 1'b0;
            if (reg_wdata[S_WERR]) werr <= 1'b0;
            if (reg_wdata[S_DONE]) done <= 1'b0;
         end
         if (set_p)  perr <= 1'b1;
         if (set_a)  aerr <= 1'b1;
         if (set_w)  werr <= 1'b1;
         if (op_end) done <= 1'b1;

         if (launch) begin
            op_q     <= op_n;
            op_idx_q <= idx_n;
            d0_q     <= d0_n;
            d1_q     <= d1_n;
         end
      end
   end

   always_comb begin
      if (busy)      st_code = ST_BUSY;
      else if (werr) st_code = ST_WPERR;
      else if (perr) st_code = ST_PGERR;
      else if (aerr) st_code = ST_ALERR;
      else           st_code = ST_READY;
   end

   always_comb begin
      case (reg_addr)
         OFS_CTRL: reg_rdata = {24'd0, locked, rie, eie, m_wide, 1'b0,
                                m_merase, m_perase, m_prog};
         OFS_ADDR: reg_rdata = {{(32-AW){1'b0}}, addr_q};
         OFS_STAT: reg_rdata = {21'd0, st_code, 3'd0, done, werr, aerr, perr, busy};
         OFS_WAIT: reg_rdata = {{(32-WS_W){1'b0}}, ws_q};
         default:  reg_rdata = 32'd0;
      endcase
   end

   assign irq = (done & eie) | ((perr | aerr | werr) & rie);
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       locked,
   input logic       busy,
   input logic       done_f,
   input logic       perr_f,
   input logic       aerr_f,
   input logic       werr_f,
   input logic       perr_clr,
   input logic       arr_wr,
   input logic [2:0] st_code,
   input logic       irq
);
   // R1
   reset_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> locked);

   // R3
   locked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !busy) |=> !busy);

   // R10
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_f) |-> $past(busy));

   // R10
   busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_f);

   // R11
   perr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_clr && !arr_wr) |=> !perr_f);

   // R12
   busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (st_code == 3'd1));

   // R12
   wp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && werr_f) |-> (st_code == 3'd2));

   // R13
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_f || perr_f || aerr_f || werr_f) |-> !irq);
endmodule

bind flash_cmd_seq fsq_checker u_chk (
   .clk(clk), .rst_n(rst_n), .locked(locked), .busy(busy),
   .done_f(done), .perr_f(perr), .aerr_f(aerr), .werr_f(werr),
   .perr_clr(reg_wr && (reg_addr == 3'd3) && reg_wdata[1]),
   .arr_wr(arr_wr), .st_code(st_code), .irq(irq)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
   localparam logic [31:0] KA = 32'h1357_9BDF;
   localparam logic [31:0] KB = 32'h2468_ACE0;
   localparam int BCYC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        arr_wr = 1'b0;
   logic [7:0]  arr_addr = 8'd0;
   logic [31:0] arr_wdata = 32'd0;
   logic [5:0]  arr_raddr = 6'd0;
   logic [31:0] arr_rdata;
   logic        irq;

   int nchk = 0;
   int nerr = 0;
   bit reported = 1'b0;

   always #4 clk = ~clk;

   flash_cmd_seq #(.BUSY_CYC(BCYC), .KEY_A(KA), .KEY_B(KB)) u_flash_cmd_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_wr(arr_wr),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_raddr(arr_raddr),
      .arr_rdata(arr_rdata), .irq(irq)
   );

   // {byte addr, data, expected status[4:1] = done,werr,aerr,perr, expected word}
   localparam logic [75:0] VEC [0:5] = '{
      {8'h40, 32'hA5A5_0001, 4'b1000, 32'hA5A5_0001},  // R5 erased target
      {8'h44, 32'h0000_0000, 4'b1000, 32'h0000_0000},  // R5 all-zero data
      {8'h40, 32'hFFFF_FFFF, 4'b0001, 32'hA5A5_0001},  // R8 target not erased
      {8'h10, 32'h1234_5678, 4'b0100, 32'hFFFF_FFFF},  // R7 protected page
      {8'hFC, 32'h0BAD_F00D, 4'b1000, 32'h0BAD_F00D},  // R5 last word
      {8'h46, 32'h5555_AAAA, 4'b0001, 32'h0000_0000}   // R5/R8 low bits ignored
   };

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr_arr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      arr_addr = a; arr_wdata = d; arr_wr = 1'b1;
      @(negedge clk);
      arr_wr = 1'b0;
   endtask

   task automatic rd_arr(input logic [7:0] a, output logic [31:0] d);
      arr_raddr = a[7:2];
      #1;
      d = arr_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 1000; i++) begin
         rd_reg(3'd3, s);
         if (s[0] == 1'b0) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      logic [31:0] v;
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd_reg(3'd1, v); chk("R1 ctrl after reset", v, 32'h80);
      rd_reg(3'd3, v); chk("R1 status after reset", v, 32'h0);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);

      // locked: everything ignored
      wr_reg(3'd1, 32'h01);
      rd_reg(3'd1, v); chk("R3 ctrl write ignored", v, 32'h80);
      wr_reg(3'd2, 32'h40);
      rd_reg(3'd2, v); chk("R3 addr write ignored", v, 32'h0);
      wr_arr(8'h60, 32'h0);
      rd_reg(3'd3, v); chk("R3 no busy when locked", v, 32'h0);
      rd_arr(8'h60, v); chk("R3 array untouched", v, 32'hFFFF_FFFF);

      // unlock
      wr_reg(3'd0, KA);
      wr_reg(3'd0, KB);
      rd_reg(3'd1, v); chk("R1 unlocked", v, 32'h00);

      // word program vectors
      wr_reg(3'd1, 32'h01);
      for (int i = 0; i < 6; i++) begin
         wr_reg(3'd3, 32'h1E);
         wr_arr(VEC[i][75:68], VEC[i][67:36]);
         wait_idle();
         rd_reg(3'd3, v);
         chk($sformatf("R5/R7/R8 vector %0d flags", i), {28'd0, v[4:1]}, {28'd0, VEC[i][35:32]});
         rd_arr(VEC[i][75:68], v);
         chk($sformatf("R5/R7/R8 vector %0d word", i), v, VEC[i][31:0]);
      end

      // double-word program
      wr_reg(3'd3, 32'h1E);
      wr_reg(3'd1, 32'h11);
      wr_arr(8'h48, 32'hCAFE_0001);
      rd_arr(8'h48, v); chk("R6 first half not yet written", v, 32'hFFFF_FFFF);
      wr_arr(8'h4C, 32'hCAFE_0002);
      wait_idle();
      rd_arr(8'h48, v); chk("R6 low word", v, 32'hCAFE_0001);
      rd_arr(8'h4C, v); chk("R6 high word", v, 32'hCAFE_0002);
      rd_reg(3'd3, v); chk("R6 done flag", {28'd0, v[4:1]}, 32'h8);

      wr_reg(3'd3, 32'h1E);
      wr_arr(8'h54, 32'h1);
      rd_reg(3'd3, v); chk("R9 misaligned first", {28'd0, v[4:1]}, 32'h2);
      wr_reg(3'd3, 32'h1E);
      wr_arr(8'h58, 32'h1);
      wr_arr(8'h60, 32'h2);
      rd_reg(3'd3, v); chk("R9 wrong second address", {28'd0, v[4:1]}, 32'h2);
      rd_arr(8'h58, v); chk("R9 nothing programmed", v, 32'hFFFF_FFFF);

      // page erase with wait state 2
      wr_reg(3'd3, 32'h1E);
      wr_reg(3'd1, 32'h00);
      wr_reg(3'd4, 32'h2);
      wr_reg(3'd2, 32'h40);
      wr_reg(3'd1, 32'h0A);
      cnt = 0;
      for (int i = 0; i < 200; i++) begin
         rd_reg(3'd3, v);
         if (v[0] == 1'b0) break;
         cnt++;
         @(negedge clk);
      end
      chk("R10 busy length", cnt, BCYC * 3);
      rd_reg(3'd3, v); chk("R10 done after erase", {28'd0, v[4:1]}, 32'h8);
      rd_arr(8'h40, v); chk("R4 page word 0 erased", v, 32'hFFFF_FFFF);
      rd_arr(8'h4C, v); chk("R4 page word 3 erased", v, 32'hFFFF_FFFF);
      rd_arr(8'hFC, v); chk("R4 other page kept", v, 32'h0BAD_F00D);
      wr_reg(3'd4, 32'h0);

      // priority of state code and selective clearing
      wr_reg(3'd3, 32'h1E);
      wr_reg(3'd1, 32'h01);
      wr_arr(8'h10, 32'h0);
      wr_arr(8'hFC, 32'h0);
      wr_reg(3'd1, 32'h11);
      wr_arr(8'h04, 32'h0);
      rd_reg(3'd3, v); chk("R12 code wp first", v, 32'h20E);
      wr_reg(3'd3, 32'h08);
      rd_reg(3'd3, v); chk("R11/R12 code program error", v, 32'h306);
      wr_reg(3'd3, 32'h02);
      rd_reg(3'd3, v); chk("R11/R12 code alignment", v, 32'h404);
      wr_reg(3'd3, 32'h00);
      rd_reg(3'd3, v); chk("R11 zero write keeps flag", v, 32'h404);
      wr_reg(3'd3, 32'h04);
      rd_reg(3'd3, v); chk("R12 code ready", v, 32'h0);

      // interrupt
      wr_reg(3'd1, 32'h21);
      wr_arr(8'h80, 32'h1);
      wait_idle();
      chk("R13 irq on done", {31'd0, irq}, 32'd1);
      wr_reg(3'd3, 32'h10);
      chk("R13 irq cleared", {31'd0, irq}, 32'd0);
      wr_reg(3'd1, 32'h41);
      wr_arr(8'h80, 32'h2);
      chk("R13 irq on error", {31'd0, irq}, 32'd1);
      wr_reg(3'd3, 32'h02);
      chk("R13 irq error cleared", {31'd0, irq}, 32'd0);

      // mass erase
      wr_reg(3'd1, 32'h0C);
      wait_idle();
      rd_arr(8'h80, v); chk("R4 mass erase word", v, 32'hFFFF_FFFF);
      rd_arr(8'hFC, v); chk("R4 mass erase last", v, 32'hFFFF_FFFF);

      // relock and bad key
      wr_reg(3'd1, 32'h00);
      wr_reg(3'd1, 32'h80);
      rd_reg(3'd1, v); chk("R2 relocked", v, 32'h80);
      wr_reg(3'd1, 32'h01);
      rd_reg(3'd1, v); chk("R2 relocked ignores ctrl", v, 32'h80);
      wr_reg(3'd0, KA);
      wr_reg(3'd0, KB);
      rd_reg(3'd1, v); chk("R2 unlock again", v, 32'h00);
      wr_reg(3'd1, 32'h80);
      wr_reg(3'd0, KB);
      wr_reg(3'd0, KA);
      wr_reg(3'd0, KB);
      rd_reg(3'd1, v); chk("R2 wrong key stays locked", v, 32'h80);

      report();
      $finish;
   end
endmodule